// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block runs one complete transaction to a serial NOR flash device on a mode-0 SPI bus. A caller offers a request with an 8-bit instruction, an address length from zero to four bytes, the address itself, a data byte count and a direction flag. Once the engine takes the request, it pulls chip select low and clocks out the instruction, then the address bytes, then the data phase. In that phase it either sends bytes taken from a write stream or receives bytes onto a read stream. It then raises chip select, waits out a guard interval and pulses `done`.

Every instruction goes through the same variable-length address phase. Instructions with no address, such as write enable, write disable, status read and identification read, use a length of zero. A discoverable-parameter read uses a length of four, and its trailing dummy byte travels as the low address byte. The engine does not interpret the instruction. The caller handles status polling, page splitting and device discovery.

The data streams are valid/ready. On the write stream a byte moves when `wr_valid` and `wr_ready` are both high on a rising clock edge. If the caller holds `wr_valid` low, the bus pauses between bytes with SCLK low and chip select held low. On the read stream the engine keeps `rd_valid` and `rd_data` steady until `rd_ready` takes the byte, and it clocks no further byte until then. The request port is a plain valid/ready pair, and `req_ready` is high only while the engine is idle.

Top module: `spi_flash_cmd_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1 and `done` is 0. Whenever `req_ready` is 1, chip select is high.
- R2: Chip select stays low from before the first SCLK rising edge until after the last one of the transaction, and returns high before `done`. Each transaction has exactly 8*(1 + address bytes + data bytes) SCLK rising edges.
- R3: The instruction byte is the first byte on MOSI. Every byte on the bus is sent most significant bit first.
- R4: With an address length n from 0 to 4, address byte i (counting from 0) is bits [8*(n-1-i) +: 8] of `req_addr`, so the most significant byte goes first. Length 0 sends no address byte.
- R5: During a read data phase MOSI carries 0x00 for every byte. Each byte sampled on MISO is delivered on `rd_data` in bus order.
- R6: During a write data phase the bytes accepted on the write stream are sent in order. While `wr_valid` is low between bytes, no SCLK edge occurs and chip select stays low. `wr_ready` is only high while SCLK is low.
- R7: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold their values and SCLK stays low.
- R8: SCLK idles low. Within a byte its period is SCLK_DIV system clocks. MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R9: A request is taken only when `req_valid` and `req_ready` are both 1. A request offered while a transaction is in progress has no effect.
- R10: Between two transactions chip select stays high for at least SCLK_DIV system clock cycles.
- R11: `done` is a single-cycle pulse. It is raised with chip select high, in the first cycle `req_ready` is back to 1, and only after the last read byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_opcode | input | 8 | Instruction byte |
| req_addr_bytes | input | 3 | Number of address bytes, 0 to MAX_ADDR_BYTES |
| req_addr | input | 8*MAX_ADDR_BYTES | Address, right-aligned |
| req_len | input | LEN_W | Number of data bytes |
| req_read | input | 1 | 1: receive data, 0: send data |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Engine takes the write byte this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-transaction pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the engine with SCLK_DIV = 6, four address bytes at most and an 8-bit length. A half period of three cycles leaves room to see that MOSI holds steady while SCLK is high and that the guard interval on chip select is counted in whole cycles. The full four-byte address path is exercised, which covers the dummy byte of a parameter read. A device model in the bench drives MISO on falling SCLK edges and captures MOSI on rising edges. Write and read stalls of a hundred cycles show that the bus freezes with chip select held low while a stream waits.

// File: rtl/spifc_pkg.sv
package spifc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_INSTR,
    SQ_ADDR,
    SQ_DATA,
    SQ_HOLD,
    SQ_GAP
  } seq_state_e;

  localparam logic [7:0] OP_READ      = 8'h03;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam logic [7:0] OP_ERASE_4K  = 8'h20;
  localparam logic [7:0] OP_ERASE_ALL = 8'hC7;
  localparam logic [7:0] OP_PARAM_RD  = 8'h5A;
  localparam logic [7:0] OP_WR_EN     = 8'h06;
  localparam logic [7:0] OP_WR_DIS    = 8'h04;
  localparam logic [7:0] OP_STATUS    = 8'h05;
  localparam logic [7:0] OP_IDENT     = 8'h9F;

endpackage

// File: rtl/spifc_shift.sv
module spifc_shift #(
  parameter int SCLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int HCW  = $clog2(HALF + 1);
  localparam logic [HCW-1:0] HALF_M1 = HCW'(HALF - 1);

  logic [HCW-1:0] hcnt_q;
  logic [2:0]     bit_q;
  logic [7:0]     sreg_q;
  logic           samp_q;
  logic           busy_q, done_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      bit_q  <= '0;
      sreg_q <= '0;
      samp_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          sreg_q <= tx_byte;
          busy_q <= 1'b1;
          hcnt_q <= HALF_M1;
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (hcnt_q != '0) begin
        hcnt_q <= hcnt_q - HCW'(1);
      end else begin
        hcnt_q <= HALF_M1;
        if (!sclk_q) begin
          // rising edge: sample the device
          sclk_q <= 1'b1;
          samp_q <= miso;
        end else begin
          // falling edge: present the next bit
          sclk_q <= 1'b0;
          sreg_q <= {sreg_q[6:0], samp_q};
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign byte_done = done_q;
  assign rx_byte   = sreg_q;
  assign sclk      = sclk_q;
  assign mosi      = busy_q & sreg_q[7];

endmodule

// File: rtl/spifc_seq.sv
module spifc_seq
  import spifc_pkg::*;
#(
  parameter int SCLK_DIV       = 4,
  parameter int MAX_ADDR_BYTES = 4,
  parameter int LEN_W          = 8,
  localparam int ADDR_W        = 8 * MAX_ADDR_BYTES,
  localparam int AB_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [AB_W-1:0]   req_addr_bytes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_read,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              cs_n,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              sh_start,
  output logic [7:0]        sh_tx
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int CW   = $clog2(SCLK_DIV + 1);
  localparam logic [CW-1:0]   HALF_M1 = CW'(HALF - 1);
  localparam logic [CW-1:0]   DIV_M1  = CW'(SCLK_DIV - 1);
  localparam logic [AB_W-1:0] MAXB    = AB_W'(MAX_ADDR_BYTES);

  seq_state_e        state_q;
  logic [7:0]        opc_q;
  logic [AB_W-1:0]   nab_q, idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              read_q, cs_q, rdv_q, done_q;
  logic [7:0]        rdd_q;
  logic [CW-1:0]     cnt_q;
  logic [AB_W+2:0]   align_sh;
  logic              can_go;

  assign can_go   = !sh_busy && !sh_done;
  assign align_sh = {MAXB - req_addr_bytes, 3'b000};

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    wr_ready = 1'b0;
    unique case (state_q)
      SQ_INSTR: begin
        sh_start = can_go;
        sh_tx    = opc_q;
      end
      SQ_ADDR: begin
        sh_start = can_go;
        sh_tx    = addr_q[ADDR_W-1 -: 8];
      end
      SQ_DATA: begin
        if (read_q) begin
          sh_start = can_go && !rdv_q;
        end else begin
          wr_ready = can_go;
          sh_start = can_go && wr_valid;
          sh_tx    = wr_data;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      opc_q   <= '0;
      nab_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      read_q  <= 1'b0;
      cs_q    <= 1'b1;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (req_valid) begin
          opc_q   <= req_opcode;
          nab_q   <= req_addr_bytes;
          idx_q   <= '0;
          addr_q  <= req_addr << align_sh;
          left_q  <= req_len;
          read_q  <= req_read;
          cs_q    <= 1'b0;
          cnt_q   <= HALF_M1;
          state_q <= SQ_SETUP;
        end
        SQ_SETUP: begin
          if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
          else state_q <= SQ_INSTR;
        end
        SQ_INSTR: if (sh_done) begin
          cnt_q <= HALF_M1;
          if (nab_q != '0)        state_q <= SQ_ADDR;
          else if (left_q != '0)  state_q <= SQ_DATA;
          else                    state_q <= SQ_HOLD;
        end
        SQ_ADDR: if (sh_done) begin
          addr_q <= addr_q << 8;
          cnt_q  <= HALF_M1;
          if (idx_q == nab_q - AB_W'(1)) begin
            state_q <= (left_q != '0) ? SQ_DATA : SQ_HOLD;
          end else begin
            idx_q <= idx_q + AB_W'(1);
          end
        end
        SQ_DATA: if (sh_done) begin
          if (read_q) begin
            rdv_q <= 1'b1;
            rdd_q <= sh_rx;
          end
          left_q <= left_q - LEN_W'(1);
          cnt_q  <= HALF_M1;
          if (left_q == LEN_W'(1)) state_q <= SQ_HOLD;
        end
        SQ_HOLD: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else begin
            cs_q    <= 1'b1;
            cnt_q   <= DIV_M1;
            state_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
          end else if (!rdv_q || rd_ready) begin
            done_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == SQ_IDLE);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign done      = done_q;
  assign cs_n      = cs_q;

endmodule

// File: rtl/spi_flash_cmd_engine.sv
module spi_flash_cmd_engine #(
  parameter int SCLK_DIV       = 4,
  parameter int MAX_ADDR_BYTES = 4,
  parameter int LEN_W          = 8,
  localparam int ADDR_W        = 8 * MAX_ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_opcode,
  input  logic [2:0]        req_addr_bytes,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_read,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              done,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic       sh_busy, sh_done, sh_start;
  logic [7:0] sh_rx, sh_tx;

  spifc_seq #(
    .SCLK_DIV(SCLK_DIV), .MAX_ADDR_BYTES(MAX_ADDR_BYTES), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr_bytes(req_addr_bytes),
    .req_addr(req_addr), .req_len(req_len), .req_read(req_read),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .cs_n(spi_cs_n),
    .sh_busy(sh_busy), .sh_done(sh_done), .sh_rx(sh_rx),
    .sh_start(sh_start), .sh_tx(sh_tx)
  );

  spifc_shift #(.SCLK_DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
    .busy(sh_busy), .byte_done(sh_done), .rx_byte(sh_rx),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

endmodule

// File: rtl/spifc_checker.sv
module spifc_checker #(
  parameter int SCLK_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       spi_sclk,
  input logic       spi_cs_n,
  input logic       spi_mosi
);
  localparam int CW = $clog2(SCLK_DIV + 1);
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= CW'(SCLK_DIV);
    else if (!spi_cs_n) gap_q <= '0;
    else if (gap_q < CW'(SCLK_DIV)) gap_q <= gap_q + CW'(1);
  end

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_cs_n); // R1
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R8
  AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R8
  AST_WR_READY_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !spi_sclk); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R7
  AST_RD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sclk); // R7
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(req_valid && req_ready)); // R9
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (gap_q >= CW'(SCLK_DIV))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && req_ready)); // R11

endmodule

bind spi_flash_cmd_engine spifc_checker #(.SCLK_DIV(SCLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .done(done), .spi_sclk(spi_sclk),
  .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/spi_flash_cmd_engine_test.sv
module spi_flash_cmd_engine_test;
  localparam int DIV = 6;
  localparam int MAXB = 4;
  localparam int LW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_read = 1'b0;
  logic [7:0] req_opcode = '0;
  logic [2:0] req_addr_bytes = '0;
  logic [31:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0, wr_ready, rd_valid, rd_ready = 1'b0, done;
  logic [7:0] wr_data = '0, rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  spi_flash_cmd_engine #(.SCLK_DIV(DIV), .MAX_ADDR_BYTES(MAXB), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr_bytes(req_addr_bytes), .req_addr(req_addr),
    .req_len(req_len), .req_read(req_read), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  int tests_run = 0, tests_failed = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model
  logic [7:0] resp [16];
  logic [7:0] cap [16];
  logic [7:0] shin = '0;
  int rise_n = 0, fall_n = 0, last_rise = 0, min_per = 1000, max_per = 0;
  int hi_at = 0, min_gap = 1000, cs_falls = 0;
  bit seen_fall = 0;

  always @(posedge clk) cyc++;

  always @(negedge spi_cs_n) begin
    rise_n = 0; fall_n = 0; cs_falls++;
    if (seen_fall && (cyc - hi_at) < min_gap) min_gap = cyc - hi_at;
    seen_fall = 1;
  end
  always @(posedge spi_cs_n) hi_at = cyc;

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shin = {shin[6:0], spi_mosi};
    if (rise_n % 8 != 0) begin
      if (cyc - last_rise < min_per) min_per = cyc - last_rise;
      if (cyc - last_rise > max_per) max_per = cyc - last_rise;
    end
    last_rise = cyc;
    if (rise_n % 8 == 7 && rise_n < 128) cap[rise_n / 8] = shin;
    rise_n++;
  end
  always @(negedge spi_sclk) if (!spi_cs_n) fall_n++;

  always_comb begin
    int bi;
    bi = fall_n / 8;
    if (bi > 15) bi = 15;
    spi_miso = spi_cs_n ? 1'b0 : resp[bi][7 - (fall_n % 8)];
  end

  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  // generic transaction driver; stall_at: stream byte index to stall before
  task automatic xfer(input logic [7:0] op, input int n, input logic [31:0] addr,
                      input int len, input bit rd, input int stall_at, input bit glitch);
    int widx, ridx, scnt, it, r_mark, falls0;
    logic [7:0] hold_d;
    widx = 0; ridx = 0; scnt = 0; it = 0; r_mark = 0; hold_d = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    falls0 = cs_falls;
    req_opcode = op; req_addr_bytes = 3'(n); req_addr = addr;
    req_len = LW'(len); req_read = rd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      @(negedge clk);
      it++;
      if (done || it > 20000) break;
      if (glitch && it >= 20 && it < 30) begin
        req_valid = 1'b1; req_opcode = 8'hC7; req_addr_bytes = 3'd0; req_len = '0;
      end else req_valid = 1'b0;
      if (!rd) begin
        if (widx == stall_at && scnt < 100) begin
          scnt++;
          wr_valid = 1'b0;
          if (scnt == 60) r_mark = rise_n;
          if (scnt == 99) begin
            chk(rise_n == r_mark && !spi_sclk, "R6 no SCLK while write stalled", rise_n, r_mark);
            chk(!spi_cs_n, "R6 CS low while write stalled", spi_cs_n, 0);
          end
        end else wr_valid = (widx < len);
        wr_data = wbuf[widx % 16];
        if (wr_valid && wr_ready) widx++;
      end else begin
        if (rd_valid && ridx == stall_at && scnt < 100) begin
          scnt++;
          rd_ready = 1'b0;
          if (scnt == 2) begin r_mark = rise_n; hold_d = rd_data; end
          if (scnt == 99) begin
            chk(rise_n == r_mark && !spi_sclk, "R7 no SCLK while read stalled", rise_n, r_mark);
            chk(rd_valid && rd_data == hold_d, "R7 read byte held", rd_data, hold_d);
          end
        end else rd_ready = 1'b1;
        if (rd_valid && rd_ready) begin rbuf[ridx % 16] = rd_data; ridx++; end
      end
    end
    wr_valid = 1'b0; rd_ready = 1'b0; req_valid = 1'b0;
    chk(done == 1'b1, "R11 done seen", done, 1);
    chk(spi_cs_n == 1'b1, "R2 CS high at done", spi_cs_n, 1);
    chk(cs_falls == falls0 + 1, "R9 one CS frame per request", cs_falls - falls0, 1);
    chk(rise_n == 8 * (1 + n + len), "R2 SCLK rising edge count", rise_n, 8 * (1 + n + len));
    chk(cap[0] == op, "R3 instruction byte first", cap[0], op);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = 8'(addr >> (8 * (n - 1 - i)));
      chk(cap[1 + i] == e, "R4 address byte", cap[1 + i], e);
    end
    for (int i = 0; i < len; i++) begin
      if (rd) begin
        chk(cap[1 + n + i] == 8'h00, "R5 zero sent in read phase", cap[1 + n + i], 0);
        chk(rbuf[i] == resp[1 + n + i], "R5 read byte delivered", rbuf[i], resp[1 + n + i]);
      end else begin
        chk(cap[1 + n + i] == wbuf[i], "R6 write byte on bus", cap[1 + n + i], wbuf[i]);
      end
    end
    if (rd) chk(ridx == len, "R5 read byte count", ridx, len);
    else    chk(widx == len, "R6 write byte count", widx, len);
    @(negedge clk);
    chk(!done && req_ready, "R11 done single pulse", done, 0);
  endtask

  task automatic t_reset;
    chk(spi_cs_n == 1'b1, "R1 CS after reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R1 SCLK after reset", spi_sclk, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1 done after reset", done, 0);
  endtask

  task automatic t_write_enable;   // R3 no-address no-data
    xfer(8'h06, 0, 32'h0, 0, 1'b0, -1, 1'b0);
  endtask

  task automatic t_ident;          // R5 three-byte read, no address
    resp[1] = 8'hC2; resp[2] = 8'h28; resp[3] = 8'h17;
    xfer(8'h9F, 0, 32'h0, 3, 1'b1, -1, 1'b0);
  endtask

  task automatic t_read_stall;     // R4 R7 three-byte address with read back-pressure
    resp[4] = 8'h11; resp[5] = 8'h22; resp[6] = 8'h33; resp[7] = 8'h44;
    xfer(8'h03, 3, 32'h00A1B2C3, 4, 1'b1, 1, 1'b0);
  endtask

  task automatic t_param_read;     // R4 four address bytes, low one the dummy
    resp[5] = 8'h53; resp[6] = 8'h46;
    xfer(8'h5A, 4, 32'h00A5C300, 2, 1'b1, -1, 1'b0);
  endtask

  task automatic t_program_stall;  // R6 write stream stalls mid-phase
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5; wbuf[2] = 8'h3C;
    xfer(8'h02, 3, 32'h000F0E0D, 3, 1'b0, 1, 1'b0);
  endtask

  task automatic t_erase_glitch;   // R9 request during transfer ignored
    int f0;
    xfer(8'h20, 3, 32'h00012000, 0, 1'b0, -1, 1'b1);
    f0 = cs_falls;
    repeat (40) @(negedge clk);
    chk(cs_falls == f0 && spi_cs_n, "R9 busy-time request left no frame", cs_falls, f0);
  endtask

  task automatic t_back_to_back;   // R10 R8 timing
    xfer(8'h04, 0, 32'h0, 0, 1'b0, -1, 1'b0);
    xfer(8'h05, 0, 32'h0, 1, 1'b1, -1, 1'b0);
    chk(min_gap >= DIV, "R10 CS high gap", min_gap, DIV);
    chk(min_per == DIV && max_per == DIV, "R8 SCLK period", min_per, DIV);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin resp[i] = 8'h00; cap[i] = 8'h00; wbuf[i] = 8'h00; rbuf[i] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_enable();
    t_ident();
    t_read_stall();
    t_param_read();
    t_program_stall();
    t_erase_glitch();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule